// File: doc/BRIEF.md
# Two-Wire Packet Link Target Endpoint

This block is the target end of a point-to-point serial link that runs over two wires: a clock that the host always drives, and one data line that both sides share. While the target is busy, it leaves the data line undriven, and the host, which polls one bit at a time, reads a pulled-down 0. Once local logic raises `localReady`, the endpoint answers the next poll with a two-bit sync pattern. It drives 1 on the first clock and 0 on the second, so the host can confirm the target is keeping pace. It then lets go of the line and samples a direction bit from the host.

After the direction bit, one packet moves in the chosen direction. The packet is a length byte followed by that many payload bytes, sent most significant bit first. Bytes arriving from the host go into a receive FIFO, length byte included, and local logic drains them through a ready/valid port. Bytes sent to the host come from a transmit FIFO that local logic fills with the length byte and then the payload. When the target is the sender, it releases the line on the clock after its last bit. Both FIFOs are run from a fast local clock. The host clock and data are synchronised into that clock domain, and its edges are detected there.

A sticky error flag records an empty transmit FIFO or a full receive FIFO during a packet. The packet still runs to its declared length, so both ends stay in step.

Top module: `linkEndpoint`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `lineOe` is 0, `errFlag` is 0, `rxValid` is 0 and `txReady` is 1.
- R2: While `localReady` is 0 in idle, every host clock leaves `lineOe` at 0, so the host reads 0 on each poll.
- R3: With `localReady` at 1 in idle, the next host clock drives the line to 1. The clock after that actively drives it to 0. On the third clock the line is released (`lineOe` = 0).
- R4: The bit the host drives on the third clock selects the direction: 1 = host to target (receive), 0 = target to host (send).
- R5: When receiving, the bits sampled on falling host-clock edges, MSB first, form the length byte and then the payload bytes. All of them are written to the receive FIFO in arrival order, length byte first.
- R6: When sending, the endpoint pops the length byte and then the payload bytes from the transmit FIFO. It drives each bit MSB first with `lineOe` = 1, changing `lineDout` only while `lineClk` is high (after a rising edge).
- R7: After the last bit it sends, the endpoint releases the line on the next rising host-clock edge (postamble clock) before it can present a new preamble. `lineOe` changes only while `lineClk` is high.
- R8: A length byte of 0 ends the packet straight after that byte, in both directions. When sending, the postamble clock still follows.
- R9: If the transmit FIFO is empty when a byte must start, the byte sent is 0x00 and `errFlag` is set. A 0x00 length ends the packet; otherwise the packet runs to its declared length.
- R10: A byte completed while the receive FIFO holds FIFO_DEPTH bytes is dropped and sets `errFlag`. The packet still runs to its declared length.
- R11: `errFlag` stays at 1 until reset, through later error-free packets.
- R12: `txReady` is 0 exactly when the transmit FIFO holds FIFO_DEPTH bytes. `rxValid` is 1 while the receive FIFO is not empty. A held `rxValid` without `rxReady` keeps `rxData` stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, much faster than the host clock |
| rst | input | 1 | Synchronous active-high reset |
| lineClk | input | 1 | Host-driven link clock |
| lineDin | input | 1 | Data line as seen by the target |
| lineDout | output | 1 | Value driven onto the data line |
| lineOe | output | 1 | Drive enable for the data line |
| localReady | input | 1 | Local logic can take part in a transaction |
| txData | input | 8 | Byte pushed into the transmit FIFO |
| txValid | input | 1 | `txData` is valid |
| txReady | output | 1 | Transmit FIFO has room |
| rxData | output | 8 | Head of the receive FIFO |
| rxValid | output | 1 | Receive FIFO is not empty |
| rxReady | input | 1 | Local logic takes `rxData` |
| errFlag | output | 1 | Sticky underflow/overflow flag |

## Verification
The link side and the local side can act on the receive FIFO in the same local cycle: a byte completes on a falling host-clock edge just as local logic pops the head. The bench provokes this by toggling `rxReady` at random on every local cycle while packets of random length arrive, and by stopping the drain entirely to fill the FIFO. It judges the result by comparing the full sequence of drained bytes with the bytes the host sent, and by requiring `errFlag` to stay clear unless the FIFO was actually full at a byte boundary.

// File: rtl/linkPkg.sv
package linkPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE1,
    ST_PRE0,
    ST_DIR,
    ST_RX,
    ST_TX,
    ST_TXEND
  } linkState_e;

  // strobes from control to datapath, valid for one local cycle
  typedef struct packed {
    logic drvOne;
    logic drvZero;
    logic txLoad;
    logic txShift;
    logic rxShift;
    logic rxPush;
  } dpCtl_t;
endpackage

// File: rtl/linkSync.sv
module linkSync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lineClk,
  input  logic lineDin,
  output logic hostRise,
  output logic hostFall,
  output logic dinSync
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   clkPipe;
  logic [SYNC_STAGES-1:0] dinPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPipe <= '0;
      dinPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-1:0], lineClk};
      dinPipe <= {dinPipe[SYNC_STAGES-2:0], lineDin};
    end
  end

  // data pipe is aligned with clkPipe[TOP]
  assign hostRise = clkPipe[TOP] & ~clkPipe[TOP+1];
  assign hostFall = ~clkPipe[TOP] & clkPipe[TOP+1];
  assign dinSync  = dinPipe[TOP];
endmodule

// File: rtl/linkFifo.sv
module linkFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] headData,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign doPush   = pushEn && !full;
  assign doPop    = popEn && !empty;
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end
endmodule

// File: rtl/linkDatapath.sv
module linkDatapath
  import linkPkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic              dinSync,
  output logic              lineDout,
  output logic              txEmpty,
  output logic              rxFull,
  output logic [BYTE_W-1:0] txByteNow,
  output logic [BYTE_W-1:0] rxByteNow,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady
);
  logic [BYTE_W-1:0] txShReg, rxShReg, txHead;
  logic              txFull, rxEmpty;

  linkFifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) uTxFifo (
    .clk(clk), .rst(rst),
    .pushEn(txValid), .pushData(txData),
    .popEn(ctl.txLoad), .headData(txHead),
    .full(txFull), .empty(txEmpty)
  );

  linkFifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) uRxFifo (
    .clk(clk), .rst(rst),
    .pushEn(ctl.rxPush), .pushData(rxByteNow),
    .popEn(rxReady), .headData(rxData),
    .full(rxFull), .empty(rxEmpty)
  );

  assign txReady   = !txFull;
  assign rxValid   = !rxEmpty;
  assign txByteNow = txEmpty ? '0 : txHead;
  assign rxByteNow = {rxShReg[BYTE_W-2:0], dinSync};

  always_ff @(posedge clk) begin
    if (rst) begin
      lineDout <= 1'b0;
      txShReg  <= '0;
      rxShReg  <= '0;
    end else begin
      if (ctl.drvOne) begin
        lineDout <= 1'b1;
      end else if (ctl.drvZero) begin
        lineDout <= 1'b0;
      end else if (ctl.txLoad) begin
        lineDout <= txByteNow[BYTE_W-1];
        txShReg  <= {txByteNow[BYTE_W-2:0], 1'b0};
      end else if (ctl.txShift) begin
        lineDout <= txShReg[BYTE_W-1];
        txShReg  <= {txShReg[BYTE_W-2:0], 1'b0};
      end
      if (ctl.rxShift) rxShReg <= rxByteNow;
    end
  end
endmodule

// File: rtl/linkCtrl.sv
module linkCtrl
  import linkPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hostRise,
  input  logic              hostFall,
  input  logic              dinSync,
  input  logic              localReady,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic [BYTE_W-1:0] txByteNow,
  input  logic [BYTE_W-1:0] rxByteNow,
  output dpCtl_t            ctl,
  output logic              lineOe,
  output logic              errFlag
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  linkState_e        state, stateN;
  logic [BW-1:0]     bitCnt, bitCntN;
  logic              isLen, isLenN;
  logic              lastByte, lastByteN;
  logic [BYTE_W-1:0] remain, remainN;
  logic              oeN, errN;

  always_comb begin
    ctl       = '0;
    stateN    = state;
    bitCntN   = bitCnt;
    isLenN    = isLen;
    lastByteN = lastByte;
    remainN   = remain;
    oeN       = lineOe;
    errN      = errFlag;
    case (state)
      ST_IDLE: if (hostRise && localReady) begin
        ctl.drvOne = 1'b1;
        oeN        = 1'b1;
        stateN     = ST_PRE1;
      end
      ST_PRE1: if (hostRise) begin
        ctl.drvZero = 1'b1;
        stateN      = ST_PRE0;
      end
      ST_PRE0: if (hostRise) begin
        oeN    = 1'b0;
        stateN = ST_DIR;
      end
      ST_DIR: if (hostFall) begin
        bitCntN   = '0;
        isLenN    = 1'b1;
        lastByteN = 1'b0;
        stateN    = dinSync ? ST_RX : ST_TX;
      end
      ST_RX: if (hostFall) begin
        ctl.rxShift = 1'b1;
        bitCntN     = bitCnt + BW'(1);
        if (bitCnt == LAST_BIT) begin
          ctl.rxPush = 1'b1;
          if (rxFull) errN = 1'b1;
          if (isLen) begin
            isLenN  = 1'b0;
            remainN = rxByteNow;
            if (rxByteNow == '0) stateN = ST_IDLE;
          end else begin
            remainN = remain - BYTE_W'(1);
            if (remain == BYTE_W'(1)) stateN = ST_IDLE;
          end
        end
      end
      ST_TX: if (hostRise) begin
        bitCntN = bitCnt + BW'(1);
        if (bitCnt == '0) begin
          ctl.txLoad = 1'b1;
          oeN        = 1'b1;
          if (txEmpty) errN = 1'b1;
          if (isLen) begin
            isLenN    = 1'b0;
            remainN   = txByteNow;
            lastByteN = (txByteNow == '0);
          end else begin
            remainN   = remain - BYTE_W'(1);
            lastByteN = (remain == BYTE_W'(1));
          end
        end else begin
          ctl.txShift = 1'b1;
          if (bitCnt == LAST_BIT && lastByte) stateN = ST_TXEND;
        end
      end
      ST_TXEND: if (hostRise) begin
        oeN    = 1'b0;
        stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      isLen    <= 1'b0;
      lastByte <= 1'b0;
      remain   <= '0;
      lineOe   <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      isLen    <= isLenN;
      lastByte <= lastByteN;
      remain   <= remainN;
      lineOe   <= oeN;
      errFlag  <= errN;
    end
  end
endmodule

// File: rtl/linkEndpoint.sv
module linkEndpoint
  import linkPkg::*;
#(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lineClk,
  input  logic              lineDin,
  output logic              lineDout,
  output logic              lineOe,
  input  logic              localReady,
  input  logic [BYTE_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              errFlag
);
  logic              hostRise, hostFall, dinSync;
  logic              txEmpty, rxFull;
  logic [BYTE_W-1:0] txByteNow, rxByteNow;
  dpCtl_t            ctl;

  linkSync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rst(rst), .lineClk(lineClk), .lineDin(lineDin),
    .hostRise(hostRise), .hostFall(hostFall), .dinSync(dinSync)
  );

  linkCtrl uCtrl (
    .clk(clk), .rst(rst), .hostRise(hostRise), .hostFall(hostFall),
    .dinSync(dinSync), .localReady(localReady), .txEmpty(txEmpty),
    .rxFull(rxFull), .txByteNow(txByteNow), .rxByteNow(rxByteNow),
    .ctl(ctl), .lineOe(lineOe), .errFlag(errFlag)
  );

  linkDatapath #(.FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .dinSync(dinSync),
    .lineDout(lineDout), .txEmpty(txEmpty), .rxFull(rxFull),
    .txByteNow(txByteNow), .rxByteNow(rxByteNow),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady)
  );
endmodule

// File: rtl/linkEndpointChecker.sv
module linkEndpointChecker (
  input logic       clk,
  input logic       rst,
  input logic       lineClk,
  input logic       lineDout,
  input logic       lineOe,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxReady,
  input logic       errFlag
);
  // R1: outputs quiet in the cycle after a reset cycle
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!lineOe && !errFlag && !rxValid));

  // R6: driven value only moves while the host clock is high
  assert_drive_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(lineDout) |-> lineClk);

  // R7: taking or releasing the line only happens after a rising edge
  assert_release_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(lineOe) |-> lineClk);

  // R11: the error flag never clears outside reset
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R12: an unaccepted head byte stays put
  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));
endmodule

bind linkEndpoint linkEndpointChecker uChk (.*);

// File: tb/sim_linkEndpoint.sv
`timescale 1ns/1ps
module sim_linkEndpoint;
  localparam int DEPTH = 8;
  localparam int HALF  = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lineClk = 1'b0;
  logic       hostDrv = 1'b0;
  logic       hostVal = 1'b0;
  logic       lineDin;
  logic       lineDout, lineOe;
  logic       localReady = 1'b0;
  logic [7:0] txData = '0;
  logic       txValid = 1'b0;
  logic       txReady;
  logic [7:0] rxData;
  logic       rxValid;
  logic       rxReady = 1'b0;
  logic       errFlag;
  logic       drainEn = 1'b0;

  int nChecks = 0;
  int nFail   = 0;
  logic [7:0] rxGot [$];

  assign lineDin = hostDrv & hostVal;   // undriven line reads low

  always #2.5 clk = ~clk;

  linkEndpoint #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .lineClk(lineClk), .lineDin(lineDin),
    .lineDout(lineDout), .lineOe(lineOe), .localReady(localReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .errFlag(errFlag)
  );

  // local consumer: random ready, records each accepted byte
  always @(negedge clk) begin
    logic r;
    r = drainEn && ($urandom % 2 == 1);
    rxReady = r;
    if (r && rxValid) rxGot.push_back(rxData);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hostBit(input logic drv, input logic val,
                         output logic seen, output logic oeSeen);
    @(negedge clk);
    lineClk = 1'b1;
    hostDrv = drv;
    hostVal = val;
    repeat (HALF) @(negedge clk);
    oeSeen  = lineOe;
    seen    = lineOe ? lineDout : lineDin;
    lineClk = 1'b0;
    repeat (HALF - 1) @(negedge clk);
  endtask

  // poll until the 1 of the preamble, then check the 0 and the release
  task automatic syncAndDir(input logic dir);
    logic s, o;
    bit found;
    found = 0;
    for (int i = 0; i < 40 && !found; i++) begin
      hostBit(1'b0, 1'b0, s, o);
      if (s) found = 1;
    end
    chk(found, "R3 preamble one", found, 1);
    hostBit(1'b0, 1'b0, s, o);
    chk(o == 1'b1 && s == 1'b0, "R3 preamble zero driven", {o, s}, 2'b10);
    hostBit(1'b1, dir, s, o);
    chk(o == 1'b0, "R3 released for dir bit", o, 0);
  endtask

  task automatic hostWrite(input logic [7:0] pkt [$]);
    logic s, o;
    syncAndDir(1'b1);
    foreach (pkt[k])
      for (int b = 7; b >= 0; b--) hostBit(1'b1, pkt[k][b], s, o);
    @(negedge clk);
    hostDrv = 1'b0;
  endtask

  task automatic hostRead(output logic [7:0] got [$]);
    logic s, o;
    logic [7:0] v;
    int len;
    got = {};
    syncAndDir(1'b0);
    @(negedge clk);
    hostDrv = 1'b0;
    len = -1;
    for (int k = 0; k <= len || len < 0; k++) begin
      v = '0;
      for (int b = 7; b >= 0; b--) begin
        hostBit(1'b0, 1'b0, s, o);
        v[b] = s;
      end
      got.push_back(v);
      if (len < 0) len = v;
      if (k >= len) break;
    end
    hostBit(1'b0, 1'b0, s, o);
    chk(o == 1'b0, "R7 postamble clock released", o, 0);
  endtask

  task automatic pushTx(input logic [7:0] b);
    @(negedge clk);
    txData  = b;
    txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic drainWait();
    drainEn = 1'b1;
    repeat (120) @(negedge clk);
    drainEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cmpQ(input string tag, input logic [7:0] act [$], input logic [7:0] exp [$]);
    bit ok;
    ok = (act.size() == exp.size());
    if (ok) foreach (exp[k]) if (act[k] !== exp[k]) ok = 0;
    if (!ok)
      for (int k = 0; k < exp.size() || k < act.size(); k++)
        if (k >= act.size() || k >= exp.size() || act[k] !== exp[k]) begin
          chk(0, tag, (k < act.size()) ? int'(act[k]) : -1, (k < exp.size()) ? int'(exp[k]) : -1);
          break;
        end
    if (ok) chk(1, tag, 0, 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] pkt [$];
    logic [7:0] got [$];
    logic s, o;
    bit quiet;
    void'($urandom(32'd20250));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(lineOe == 0, "R1 oe in reset", lineOe, 0);
    chk(errFlag == 0 && rxValid == 0 && txReady == 1, "R1 flags in reset",
        {errFlag, rxValid, txReady}, 3'b001);
    rst = 1'b0;
    @(negedge clk);

    // R2 busy: every poll reads 0, line never driven
    quiet = 1;
    for (int i = 0; i < 12; i++) begin
      hostBit(1'b0, 1'b0, s, o);
      if (s || o) quiet = 0;
    end
    chk(quiet, "R2 busy polls read zero", quiet, 1);

    // R4/R5 directed receive
    localReady = 1'b1;
    rxGot = {};
    pkt = '{8'h02, 8'hA5, 8'h3C};
    hostWrite(pkt);
    drainWait();
    cmpQ("R5 receive order", rxGot, pkt);
    chk(errFlag == 0, "R4 no error on receive", errFlag, 0);

    // R8 zero-length receive
    rxGot = {};
    pkt = '{8'h00};
    hostWrite(pkt);
    drainWait();
    cmpQ("R8 zero-length receive", rxGot, pkt);

    // R8 zero-length send
    pushTx(8'h00);
    hostRead(got);
    pkt = '{8'h00};
    cmpQ("R8 zero-length send", got, pkt);

    // R12 full tx FIFO, R6 full send
    pkt = '{8'h07, 8'h81, 8'h42, 8'hFF, 8'h00, 8'h18, 8'hC3, 8'h7E};
    foreach (pkt[k]) pushTx(pkt[k]);
    @(negedge clk);
    chk(txReady == 0, "R12 txReady low when full", txReady, 0);
    hostRead(got);
    cmpQ("R6 send order", got, pkt);
    chk(txReady == 1, "R12 txReady after drain", txReady, 1);

    // random mix, local side draining at random in both cycles of a push
    for (int it = 0; it < 10; it++) begin
      int len;
      logic dir;
      dir = ($urandom % 2) == 1;
      len = $urandom % 7;
      pkt = {};
      pkt.push_back(8'(len));
      for (int k = 0; k < len; k++) pkt.push_back(8'($urandom));
      if (dir) begin
        rxGot = {};
        drainEn = 1'b1;
        hostWrite(pkt);
        drainWait();
        cmpQ("R5 random receive", rxGot, pkt);
      end else begin
        foreach (pkt[k]) pushTx(pkt[k]);
        hostRead(got);
        cmpQ("R6 random send", got, pkt);
      end
    end
    chk(errFlag == 0, "R10 no error in random mix", errFlag, 0);

    // R10 overflow: 10 bytes into an undrained FIFO of 8
    rxGot = {};
    pkt = '{8'h09, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88, 8'h99};
    hostWrite(pkt);
    repeat (10) @(negedge clk);
    chk(errFlag == 1, "R10 overflow sets error", errFlag, 1);
    drainWait();
    pkt = pkt[0:DEPTH-1];
    cmpQ("R10 first bytes kept", rxGot, pkt);

    // R11 sticky through a clean packet, cleared by reset
    rxGot = {};
    pkt = '{8'h01, 8'hE7};
    hostWrite(pkt);
    drainWait();
    cmpQ("R11 clean packet after error", rxGot, pkt);
    chk(errFlag == 1, "R11 error still set", errFlag, 1);
    doReset();
    chk(errFlag == 0, "R11 reset clears error", errFlag, 0);

    // R9 underflow: length 3 but only one payload byte queued
    pushTx(8'h03);
    pushTx(8'h5A);
    hostRead(got);
    pkt = '{8'h03, 8'h5A, 8'h00, 8'h00};
    cmpQ("R9 underflow sends zeros", got, pkt);
    chk(errFlag == 1, "R9 underflow sets error", errFlag, 1);

    // R9 empty FIFO at length byte: length 0x00, packet ends
    doReset();
    hostRead(got);
    pkt = '{8'h00};
    cmpQ("R9 empty length byte", got, pkt);
    chk(errFlag == 1, "R9 empty length sets error", errFlag, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule